// File: doc/BRIEF.md
# SPI Block-Transfer Master with Word FIFO

This block is a register-programmed SPI master. It moves a block of bytes of programmed length between a small 32-bit word FIFO and an SPI slave, and it moves them in one direction per transfer. Software first picks an SCK rate, a direction and a byte count. It then raises chip select through the select register and sets the start bit. For a write transfer, software pushes words into the FIFO and the engine shifts their bytes out. For a read transfer, the engine packs received bytes into words and software pops them.

The shifter runs SPI mode 0: SCK idles low, the master samples MISO on the rising edge, MOSI changes on the falling edge, and the most significant bit goes first. Bytes sit in FIFO words in little-endian order. The engine stalls SCK whenever the FIFO cannot supply or accept the next byte. Chip select is controlled only by software. A request to drop it during a transfer is held until the last byte has finished.

The register bus is a simple one-cycle strobe interface. `bus_addr` is a word index, and `bus_rdata` shows the addressed register combinationally. A read strobe on the FIFO index pops the word that is on view.

Top module: `spi_blk_master`

## Requirements
- R1: After reset, chip select is high, SCK is low, the control, select and length registers read 0, and the status register reads 2 (FIFO empty, not full).
- R2: While a byte is in flight, each high phase and each low phase of SCK lasts 2^rate system clocks, where rate is control bits 2:0. SCK is low whenever no transfer is busy.
- R3: On a write transfer, each FIFO word is sent as bits 7:0, then 15:8, 23:16 and 31:24, each byte MSB first. MOSI holds steady while SCK is high. A word leaves the FIFO after its fourth byte or after the final byte.
- R4: On a read transfer, MOSI stays 1 and MISO is sampled on each SCK rising edge. Received bytes fill words from bits 7:0 upward. A final partial word is pushed with its unfilled upper bytes at zero.
- R5: Writing the control register with bit 7 set and bit 4 giving the direction (1 = write to slave, 0 = read from slave) starts a transfer if the length is non-zero. Bit 7 reads 1 until the last byte completes. A start with length 0 does nothing.
- R6: The length register (index 2) keeps bits 20:0 of a write, and its bits 31:21 read as 0.
- R7: The FIFO holds 4 words. Status (index 4) bit 0 reads 1 when the FIFO is full and bit 1 reads 1 when it is empty. A push into a full FIFO is dropped, and pops return words in push order.
- R8: A write transfer with an empty FIFO, or a read transfer with a full FIFO, holds SCK low and stays busy until software pushes or pops a word. It then continues.
- R9: Writing 1 to the select register (index 1) drives chip select low, and the register reads 1. Writing 0 while idle raises chip select at once. Writing 0 while busy keeps chip select low until the transfer ends.
- R10: While busy, writes to the control and length registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the FIFO at index 3) |
| bus_addr | input | 3 | Register word index: 0 control, 1 select, 2 length, 3 FIFO, 4 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
The assertions check on every cycle that the FIFO fill never exceeds its depth and that SCK stays low when no transfer is busy. They also check that MOSI does not move while SCK is high, that chip select cannot fall away in the middle of a transfer, and that the direction is frozen while busy. Only the bench scenarios can show byte order and word packing, zero padding of a partial read word, the exact SCK phase lengths at several rates, recovery from FIFO stalls, and the deferred deselect taking effect at the end of the transfer.

// File: rtl/spi_blk_master.sv
module spi_blk_master #(
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 21,
  parameter int RATE_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DIV_W = (1 << RATE_W) - 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_SEL = 3'd1, A_LEN = 3'd2, A_FIFO = 3'd3, A_STAT = 3'd4;

  logic [RATE_W-1:0] rate;
  logic              dir, busy, sel, drop_pend;
  logic [LEN_W-1:0]  len_q, left;
  logic [1:0]        bidx;
  logic [31:0]       mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  fill;
  logic              active;
  logic [3:0]        phase;
  logic [DIV_W-1:0]  div, half_m1;
  logic [7:0]        txs, rxs;
  logic [31:0]       pack, ctrl_view;

  wire full       = fill == CNT_W'(DEPTH);
  wire empty      = fill == '0;
  wire [31:0] head = mem[rp];
  wire [7:0] head_byte = head[8*bidx +: 8];
  wire last_byte  = left == LEN_W'(1);
  wire word_end   = (bidx == 2'd3) || last_byte;
  assign half_m1  = (DIV_W'(1) << rate) - DIV_W'(1);
  wire tick       = div == half_m1;
  wire byte_done  = active && tick && (phase == 4'd15);
  wire launch     = busy && !active && (dir ? !empty : !full);

  wire [31:0] packed_word = pack | ({24'd0, rxs} << (8*bidx));
  wire bus_push = bus_we && bus_addr == A_FIFO && !full && !(busy && !dir);
  wire bus_pop  = bus_re && bus_addr == A_FIFO && !empty && !(busy && dir);
  wire eng_push = byte_done && !dir && word_end;
  wire eng_pop  = byte_done && dir && word_end;
  wire push = bus_push || eng_push;
  wire pop  = bus_pop || eng_pop;
  wire [31:0] push_data = eng_push ? packed_word : bus_wdata;

  always_ff @(posedge clk)
    if (push) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push) wp <= wp + PTR_W'(1);
      if (pop)  rp <= rp + PTR_W'(1);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rate <= '0; dir <= 1'b0; busy <= 1'b0; sel <= 1'b0; drop_pend <= 1'b0;
      len_q <= '0; left <= '0; bidx <= '0; pack <= '0;
      active <= 1'b0; phase <= '0; div <= '0; txs <= 8'hFF; rxs <= '0; spi_sck <= 1'b0;
    end else begin
      if (launch) begin
        active <= 1'b1;
        phase  <= '0;
        div    <= '0;
        txs    <= dir ? head_byte : 8'hFF;
      end else if (active) begin
        if (!tick) div <= div + DIV_W'(1);
        else begin
          div   <= '0;
          phase <= phase + 4'd1;
          if (!phase[0]) begin
            spi_sck <= 1'b1;
            rxs     <= {rxs[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            txs     <= {txs[6:0], 1'b1};
          end
          if (phase == 4'd15) begin
            active <= 1'b0;
            left   <= left - LEN_W'(1);
            bidx   <= bidx + 2'd1;
            if (!dir) pack <= word_end ? 32'd0 : packed_word;
            if (last_byte) begin
              busy <= 1'b0;
              if (drop_pend) begin
                sel <= 1'b0;
                drop_pend <= 1'b0;
              end
            end
          end
        end
      end

      if (bus_we && bus_addr == A_CTRL && !busy) begin
        rate <= bus_wdata[RATE_W-1:0];
        dir  <= bus_wdata[4];
        if (bus_wdata[7] && len_q != '0) begin
          busy <= 1'b1;
          left <= len_q;
          bidx <= '0;
          pack <= '0;
        end
      end
      if (bus_we && bus_addr == A_LEN && !busy)
        len_q <= bus_wdata[LEN_W-1:0];
      if (bus_we && bus_addr == A_SEL) begin
        if (bus_wdata[0]) begin
          sel <= 1'b1;
          drop_pend <= 1'b0;
        end else if (busy && !(byte_done && last_byte)) drop_pend <= 1'b1;
        else sel <= 1'b0;
      end
    end

  assign spi_mosi = dir ? txs[7] : 1'b1;
  assign spi_cs_n = ~sel;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[RATE_W-1:0] = rate;
    ctrl_view[4] = dir;
    ctrl_view[7] = busy;
  end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_view;
      A_SEL:   bus_rdata = {31'd0, sel};
      A_LEN:   bus_rdata = 32'(len_q);
      A_FIFO:  bus_rdata = empty ? 32'd0 : head;
      A_STAT:  bus_rdata = {30'd0, empty, full};
      default: bus_rdata = 32'd0;
    endcase
endmodule

// File: rtl/spi_blk_master_chk.sv
module spi_blk_master_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             dir,
  input logic             sel,
  input logic [CNT_W-1:0] fill,
  input logic             spi_sck,
  input logic             spi_mosi
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= CNT_W'(DEPTH)); // R7
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !spi_sck); // R2
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R3
  AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && $past(sel)) |-> sel); // R9
  AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(dir)); // R10
endmodule

bind spi_blk_master spi_blk_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dir(dir), .sel(sel),
  .fill(fill), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_blk_master_test.sv
module spi_blk_master_test;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_sck, spi_mosi, spi_miso, spi_cs_n;

  spi_blk_master uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;

  int checks = 0, errs = 0, cur_rate = 0, hi_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  logic [7:0] s_shift = 0, s_tx = 0;
  logic [2:0] s_bit = 0;
  logic [7:0] mosi_q[$];
  logic [7:0] miso_q[$];
  assign spi_miso = s_tx[3'd7 - s_bit];

  always @(posedge spi_sck) begin
    s_shift = {s_shift[6:0], spi_mosi};
    if (s_bit == 3'd7) begin
      mosi_q.push_back(s_shift);
      s_bit = 0;
      s_tx = (miso_q.size() != 0) ? miso_q.pop_front() : 8'h00;
    end else s_bit = s_bit + 3'd1;
  end

  // per-clock SCK phase model
  always @(negedge clk) if (rst_n) begin
    if (spi_sck) hi_cnt++;
    else if (hi_cnt != 0) begin
      chk(hi_cnt == (1 << cur_rate), "R2 sck high time", hi_cnt, 1 << cur_rate);
      hi_cnt = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin rd(3'd0, v); n++; end while (v[7] && n < 20000);
  endtask

  task automatic slave_load(input logic [7:0] first, input int n);
    miso_q.delete();
    for (int i = 0; i < n; i++) miso_q.push_back(first + 8'(i));
    s_tx = miso_q.pop_front();
  endtask

  task automatic exp_byte(input logic [7:0] e, input string req);
    logic [7:0] got;
    got = (mosi_q.size() != 0) ? mosi_q.pop_front() : 8'hXX;
    chk(got === e, req, {24'd0, got}, {24'd0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sck == 0, "R1 pins", {30'd0, spi_cs_n, spi_sck}, 32'd2);
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 sel", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 len", v, 0);
    rd(3'd4, v); chk(v == 2, "R1 status", v, 2);

    // R6 length width
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk(v == 32'h001F_FFFF, "R6 len mask", v, 32'h001F_FFFF);

    // R9 select and idle deselect
    wr(3'd1, 1); chk(spi_cs_n == 0, "R9 cs low", spi_cs_n, 0);
    rd(3'd1, v); chk(v == 1, "R9 sel reads 1", v, 1);
    wr(3'd1, 0); chk(spi_cs_n == 1, "R9 idle deselect", spi_cs_n, 1);
    wr(3'd1, 1);

    // R7 FIFO depth, full flag, order
    for (int i = 0; i < 5; i++) wr(3'd3, 32'hA0 + i);
    rd(3'd4, v); chk(v == 1, "R7 full", v, 1);
    for (int i = 0; i < 4; i++) begin rd(3'd3, v); chk(v == 32'hA0 + i, "R7 order", v, 32'hA0 + i); end
    rd(3'd4, v); chk(v == 2, "R7 empty after drain", v, 2);

    // R3 write transfer, rate 0, 6 bytes
    wr(3'd3, 32'h4433_2211); wr(3'd3, 32'h0000_6655);
    wr(3'd2, 6); cur_rate = 0; wr(3'd0, 32'h90);
    wait_idle();
    exp_byte(8'h11, "R3 b0"); exp_byte(8'h22, "R3 b1"); exp_byte(8'h33, "R3 b2");
    exp_byte(8'h44, "R3 b3"); exp_byte(8'h55, "R3 b4"); exp_byte(8'h66, "R3 b5");
    rd(3'd4, v); chk(v == 2, "R3 words consumed", v, 2);

    // R2/R3 rate 2, 3 bytes partial word
    wr(3'd3, 32'h00CC_BBAA); wr(3'd2, 3); cur_rate = 2; wr(3'd0, 32'h92);
    wait_idle();
    exp_byte(8'hAA, "R3 r2 b0"); exp_byte(8'hBB, "R3 r2 b1"); exp_byte(8'hCC, "R3 r2 b2");
    rd(3'd4, v); chk(v == 2, "R3 partial word popped", v, 2);

    // R4 read transfer, rate 1, 6 bytes
    slave_load(8'h10, 6); wr(3'd2, 6); cur_rate = 1; wr(3'd0, 32'h81);
    wait_idle();
    for (int i = 0; i < 6; i++) exp_byte(8'hFF, "R4 mosi high");
    rd(3'd3, v); chk(v == 32'h1312_1110, "R4 word0", v, 32'h1312_1110);
    rd(3'd3, v); chk(v == 32'h0000_1514, "R4 padded", v, 32'h0000_1514);

    // R8 read stall on full FIFO
    slave_load(8'h20, 20); wr(3'd2, 20); cur_rate = 0; wr(3'd0, 32'h80);
    repeat (300) @(negedge clk);
    rd(3'd0, v); chk(v[7] == 1, "R8 busy in read stall", v, 32'h80);
    rd(3'd4, v); chk(v == 1, "R8 full in read stall", v, 1);
    begin
      int hi = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (spi_sck) hi++; end
      chk(hi == 0, "R8 sck held low", hi, 0);
    end
    for (int k = 0; k < 5; k++) begin
      logic [31:0] e;
      e = {8'h23 + 8'(4*k), 8'h22 + 8'(4*k), 8'h21 + 8'(4*k), 8'h20 + 8'(4*k)};
      do rd(3'd4, v); while (v[1]);
      rd(3'd3, v); chk(v == e, "R8 read resume data", v, e);
    end
    wait_idle();
    chk(mosi_q.size() == 20, "R4 read byte count", mosi_q.size(), 20);
    mosi_q.delete();

    // R8 write stall on empty FIFO, R5 busy, R10 frozen config
    wr(3'd2, 4); cur_rate = 1; wr(3'd0, 32'h91);
    repeat (50) @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (spi_sck) hi++; end
      chk(hi == 0, "R8 sck low on empty", hi, 0);
    end
    rd(3'd0, v); chk(v == 32'h91, "R5 busy bit set", v, 32'h91);
    wr(3'd2, 99); wr(3'd0, 32'h05);
    rd(3'd2, v); chk(v == 4, "R10 len frozen", v, 4);
    rd(3'd0, v); chk(v == 32'h91, "R10 ctrl frozen", v, 32'h91);
    wr(3'd3, 32'hDDCC_BBAA);
    wait_idle();
    exp_byte(8'hAA, "R8 resume b0"); exp_byte(8'hBB, "R8 resume b1");
    exp_byte(8'hCC, "R8 resume b2"); exp_byte(8'hDD, "R8 resume b3");
    rd(3'd0, v); chk(v[7] == 0, "R5 busy clears", v, 32'h11);

    // R5 zero length start ignored
    wr(3'd2, 0); wr(3'd0, 32'h90);
    rd(3'd0, v); chk(v[7] == 0, "R5 zero length", v, 32'h10);

    // R9 deferred deselect
    wr(3'd3, 32'h0403_0201); wr(3'd2, 4); cur_rate = 3; wr(3'd0, 32'h93);
    wr(3'd1, 0);
    chk(spi_cs_n == 0, "R9 cs held while busy", spi_cs_n, 0);
    rd(3'd1, v); chk(v == 1, "R9 sel still 1", v, 1);
    wait_idle();
    chk(spi_cs_n == 1, "R9 cs released at end", spi_cs_n, 1);
    rd(3'd1, v); chk(v == 0, "R9 sel reads 0", v, 0);
    exp_byte(8'h01, "R9 b0"); exp_byte(8'h02, "R9 b1");
    exp_byte(8'h03, "R9 b2"); exp_byte(8'h04, "R9 b3");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule